// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor core that completes every instruction in a single clock period. On each cycle it presents its program counter on the instruction port and decodes the returned word in the same cycle. It reads both source registers before it knows whether it needs them, computes in the ALU, and at the next rising edge writes the result back and advances the program counter. Instruction fetch and data access use two separate ports, so a load or store never competes with the fetch. Both memories are outside the block and are read combinationally.

The supported set covers register-register arithmetic, logic and compare operations, immediate forms of the same, word load and word store. The program counter only steps sequentially. There are no exceptions, no overflow trap, no pipeline and no multiply or divide. Any encoding outside the set behaves as a no-operation.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter is loaded with `RESET_PC` (default 0). In any cycle where `rst_n` is low, neither `dmem_we` nor a register write is asserted.
- R2: Out of reset, `imem_addr` equals the program counter, and the program counter advances by 4 at every rising edge.
- R3: Instruction fields are: opcode in bits 31..26, source register A in 25..21, source register B in 20..16, R-type destination in 15..11, and R-type function in 5..0. Opcode 0x00 selects R-type. The function codes are add 0x20, addu 0x21, sub 0x22, subu 0x23, and 0x24, or 0x25, xor 0x26, nor 0x27, slt 0x2A and sltu 0x2B. The result goes to the destination register.
- R4: The immediate forms take their 16-bit immediate from bits 15..0 and write their result to the register in bits 20..16. addi 0x08, addiu 0x09, slti 0x0A and sltiu 0x0B sign-extend the immediate. andi 0x0C, ori 0x0D and xori 0x0E zero-extend it.
- R5: slt and slti write 1 when the first operand is less than the second as signed values, and 0 otherwise. sltu and sltiu do the same comparison on unsigned values.
- R6: A load (opcode 0x23) drives `dmem_addr` with register A plus the sign-extended immediate. It writes `dmem_rdata` to the register in bits 20..16.
- R7: A store (opcode 0x2B) computes the same address and drives `dmem_wdata` with the register in bits 20..16. It asserts `dmem_we` for that cycle and writes no register.
- R8: Register 0 always reads as zero, and a write to it has no effect.
- R9: A register written by one instruction holds the new value for the instruction in the next cycle.
- R10: Any other opcode, and any R-type function code not listed in R3 (including 0x00), writes neither a register nor data memory.
- R11: add, addi and sub wrap modulo 2^32 and do not trap on signed overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Instruction fetch address (program counter) |
| imem_data | input | 32 | Instruction word returned for `imem_addr` in the same cycle |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Data memory store value |
| dmem_we | output | 1 | Data memory write strobe, taken at the rising edge |
| dmem_rdata | input | 32 | Data memory read value for `dmem_addr`, same cycle |

## Verification
The fetch address and the data-port outputs are combinational from the current instruction, so they are due in the same cycle. The bench samples them at the falling edge after the instruction has been presented. Register results and memory writes take effect at the next rising edge. The bench counts retired instructions as rising edges after reset is released and inspects its data array only at a falling edge after the edge that commits a store. Register values are made visible by storing them, so each checked result lands exactly one cycle after the store instruction is fetched.

// File: rtl/sc_pkg.sv
// Shared encodings and control types for the single-cycle core.
// Assumes the fixed 32-bit instruction format with 5-bit register fields.
package sc_pkg;
    localparam int REG_AW = 5;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_ADDIU = 6'h09;
    localparam logic [5:0] OPC_SLTI  = 6'h0A;
    localparam logic [5:0] OPC_SLTIU = 6'h0B;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR,
        ALU_XOR, ALU_NOR, ALU_SLT, ALU_SLTU
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;     // result goes to the register file
        logic    dst_rd;     // destination from bits 15..11 instead of 20..16
        logic    use_imm;    // ALU operand B is the extended immediate
        logic    imm_zext;   // zero-extend instead of sign-extend
        logic    from_mem;   // write-back value is the load data
        logic    mem_we;     // store to data memory
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
// Main control: turns opcode and function code into datapath selects.
// Assumes nothing about other instruction bits; unknown codes yield a no-op.
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Decode one instruction class into its control word.
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, imm_zext: 1'b0,
                 from_mem: 1'b0, mem_we: 1'b0, alu_op: ALU_ADD};
        case (opcode)
            OPC_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                case (funct)
                    FN_ADD, FN_ADDU: ctrl.alu_op = ALU_ADD;
                    FN_SUB, FN_SUBU: ctrl.alu_op = ALU_SUB;
                    FN_AND:          ctrl.alu_op = ALU_AND;
                    FN_OR:           ctrl.alu_op = ALU_OR;
                    FN_XOR:          ctrl.alu_op = ALU_XOR;
                    FN_NOR:          ctrl.alu_op = ALU_NOR;
                    FN_SLT:          ctrl.alu_op = ALU_SLT;
                    FN_SLTU:         ctrl.alu_op = ALU_SLTU;
                    default:         ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_ADDI, OPC_ADDIU: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_ADD;
            end
            OPC_SLTI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT;
            end
            OPC_SLTIU: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLTU;
            end
            OPC_ANDI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1;
                ctrl.alu_op = ALU_AND;
            end
            OPC_ORI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1;
                ctrl.alu_op = ALU_OR;
            end
            OPC_XORI: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1;
                ctrl.alu_op = ALU_XOR;
            end
            OPC_LOAD: begin
                ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_we = 1'b1; ctrl.use_imm = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
// Register file: two combinational read ports, one edge-triggered write port.
// Assumes entry 0 is hard-wired to zero; storage is not reset.
module sc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic [AW-1:0]   ra_idx,
    input  logic [AW-1:0]   rb_idx,
    output logic [XLEN-1:0] ra_val,
    output logic [XLEN-1:0] rb_val,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_val
);
    logic [XLEN-1:0] regs [NREGS];

    // Commit a write at the edge; entry 0 never changes.
    always_ff @(posedge clk) begin
        if (wr_en && wr_idx != '0) regs[wr_idx] <= wr_val;
    end

    // Combinational reads with entry 0 forced to zero.
    always_comb begin
        ra_val = (ra_idx == '0) ? '0 : regs[ra_idx];
        rb_val = (rb_idx == '0) ? '0 : regs[rb_idx];
    end
endmodule

// File: rtl/sc_alu.sv
// Integer ALU: add, subtract, bitwise ops and signed/unsigned set-less-than.
// Assumes wrap-around arithmetic; no overflow flag is produced.
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    // Select the result of the requested operation.
    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_NOR:  y = ~(a | b);
            ALU_SLT:  y = XLEN'($signed(a) < $signed(b));
            ALU_SLTU: y = XLEN'(a < b);
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC, decode, register file, extender, ALU and muxes.
// Assumes both memories answer combinationally in the same cycle.
module sc_core
    import sc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              NREGS    = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam int IMM_W = 16;

    logic [XLEN-1:0]   pc_q;
    logic [5:0]        opcode, funct;
    logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
    logic [IMM_W-1:0]  imm16;
    logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y, wb_val;
    logic              rf_we;
    ctrl_t             ctrl;

    // Program counter: load the reset vector, otherwise step one word.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_q + XLEN'(4);
    end

    assign imem_addr = pc_q;

    // Split the fetched word into its fields.
    always_comb begin
        opcode = imem_data[31:26];
        rs_idx = imem_data[25:21];
        rt_idx = imem_data[20:16];
        rd_idx = imem_data[15:11];
        funct  = imem_data[5:0];
        imm16  = imem_data[15:0];
    end

    sc_decode u_decode (.opcode(opcode), .funct(funct), .ctrl(ctrl));

    sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_regfile (
        .clk(clk), .ra_idx(rs_idx), .rb_idx(rt_idx),
        .ra_val(rs_val), .rb_val(rt_val),
        .wr_en(rf_we), .wr_idx(dst_idx), .wr_val(wb_val)
    );

    // Extend the immediate and pick operand B, destination and write-back.
    always_comb begin
        imm_ext = ctrl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, imm16}
                                : {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
        alu_b   = ctrl.use_imm  ? imm_ext : rt_val;
        dst_idx = ctrl.dst_rd   ? rd_idx  : rt_idx;
        wb_val  = ctrl.from_mem ? dmem_rdata : alu_y;
    end

    sc_alu #(.XLEN(XLEN)) u_alu (.op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y));

    // Writes of either kind are held off while reset is asserted.
    assign rf_we      = ctrl.reg_we & rst_n;
    assign dmem_we    = ctrl.mem_we & rst_n;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
// Property checker for sc_core, attached by bind below.
// Assumes it observes the core's internal register-port signals by name.
module sc_core_chk #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] imem_addr,
    input logic            dmem_we,
    input logic [XLEN-1:0] dmem_wdata,
    input logic            rf_we,
    input logic [4:0]      rs_idx,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val
);
    AST_RESET_VECTOR: assert property (@(posedge clk) !rst_n |=> imem_addr == RESET_PC); // R1
    always_comb begin
        if (!rst_n) AST_NO_WRITE_IN_RESET: assert (!dmem_we && !rf_we); // R1
    end
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> imem_addr == $past(imem_addr) + XLEN'(4)); // R2
    AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> !rf_we); // R7
    AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> dmem_wdata == rt_val); // R7
    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        rs_idx == 5'd0 |-> rs_val == '0); // R8
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .rf_we(rf_we), .rs_idx(rs_idx),
    .rs_val(rs_val), .rt_val(rt_val)
);

// File: tb/test_sc_core.sv
// Bench for sc_core: vector table of single operations, then directed programs.
module test_sc_core;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] imem [MEM_WORDS];
    logic [31:0] dmem [MEM_WORDS];
    int          n_run = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core i_sc_core (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    typedef struct packed {
        logic        is_imm;
        logic [5:0]  code;
        logic [15:0] imm;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 6'h20, 16'h0, 32'd5,          32'd7,          32'd12},
        '{1'b0, 6'h21, 16'h0, 32'hFFFFFFFF,   32'd1,          32'd0},
        '{1'b0, 6'h22, 16'h0, 32'd3,          32'd5,          32'hFFFFFFFE},
        '{1'b0, 6'h23, 16'h0, 32'h80000000,   32'd1,          32'h7FFFFFFF},
        '{1'b0, 6'h24, 16'h0, 32'hF0F0F0F0,   32'hFF00FF00,   32'hF000F000},
        '{1'b0, 6'h25, 16'h0, 32'h0F0F0000,   32'h000000F0,   32'h0F0F00F0},
        '{1'b0, 6'h26, 16'h0, 32'hAAAAAAAA,   32'hFFFF0000,   32'h5555AAAA},
        '{1'b0, 6'h27, 16'h0, 32'h0,          32'h0000FFFF,   32'hFFFF0000},
        '{1'b0, 6'h2A, 16'h0, 32'hFFFFFFFF,   32'd1,          32'd1},
        '{1'b0, 6'h2B, 16'h0, 32'hFFFFFFFF,   32'd1,          32'd0},
        '{1'b1, 6'h08, 16'hFFFF, 32'd10,      32'd0,          32'd9},
        '{1'b1, 6'h09, 16'h8000, 32'd0,       32'd0,          32'hFFFF8000},
        '{1'b1, 6'h0A, 16'hFFFE, 32'hFFFFFFFB, 32'd0,         32'd1},
        '{1'b1, 6'h0B, 16'hFFFF, 32'd5,       32'd0,          32'd1},
        '{1'b1, 6'h0C, 16'h8001, 32'hFFFFFFFF, 32'd0,         32'h00008001},
        '{1'b1, 6'h0D, 16'h8765, 32'h12340000, 32'd0,         32'h12348765},
        '{1'b1, 6'h0E, 16'hFFFF, 32'hFFFF0000, 32'd0,         32'hFFFFFFFF},
        '{1'b0, 6'h20, 16'h0, 32'h7FFFFFFF,   32'd1,          32'h80000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
    endtask

    // Hold reset for two edges, release at a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Release reset then retire n instructions, ending at a falling edge.
    task automatic run(input int n);
        do_reset();
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Vector table: load operands, run one operation, store the result.
        for (int v = 0; v < NVEC; v++) begin
            clear_mem();
            dmem[1] = VECS[v].a;
            dmem[2] = VECS[v].b;
            dmem[4] = 32'hDEADBEEF;
            imem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd4);
            imem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd8);
            imem[2] = VECS[v].is_imm ? enc_i(VECS[v].code, 5'd1, 5'd3, VECS[v].imm)
                                     : enc_r(5'd1, 5'd2, 5'd3, VECS[v].code);
            imem[3] = enc_i(6'h2B, 5'd0, 5'd3, 16'd16);
            run(4);
            chk($sformatf("R3/R4/R5/R6/R11 vector %0d", v), dmem[4], VECS[v].exp);
        end

        // Directed program: dependencies, undefined codes, zero register, offsets.
        clear_mem();
        dmem[11] = 32'hCAFEF00D;
        imem[0]  = enc_i(6'h09, 5'd0, 5'd5, 16'd1);
        imem[1]  = enc_r(5'd5, 5'd5, 5'd5, 6'h21);
        imem[2]  = enc_r(5'd5, 5'd5, 5'd5, 6'h21);
        imem[3]  = enc_i(6'h3F, 5'd5, 5'd5, 16'h1234);
        imem[4]  = enc_r(5'd5, 5'd5, 5'd5, 6'h00);
        imem[5]  = enc_i(6'h2B, 5'd0, 5'd5, 16'd20);
        imem[6]  = enc_i(6'h09, 5'd0, 5'd0, 16'd7);
        imem[7]  = enc_i(6'h2B, 5'd0, 5'd0, 16'd24);
        imem[8]  = enc_r(5'd5, 5'd5, 5'd0, 6'h21);
        imem[9]  = enc_i(6'h2B, 5'd0, 5'd0, 16'd28);
        imem[10] = enc_i(6'h09, 5'd0, 5'd1, 16'd48);
        imem[11] = enc_i(6'h2B, 5'd1, 5'd5, 16'hFFF8);
        imem[12] = enc_i(6'h23, 5'd1, 5'd6, 16'hFFFC);
        imem[13] = enc_i(6'h2B, 5'd0, 5'd6, 16'd32);
        imem[14] = enc_i(6'h2B, 5'd0, 5'd5, 16'd52);
        do_reset();
        chk("R1 fetch address after reset", imem_addr, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 fetch address after 3 steps", imem_addr, 32'd12);
        chk("R10 undefined opcode drives no store", {31'b0, dmem_we}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R10 undefined function drives no store", {31'b0, dmem_we}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 store strobe in its own cycle", {31'b0, dmem_we}, 32'd1);
        chk("R7 store address", dmem_addr, 32'd20);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R9/R10 back-to-back result survives undefined codes", dmem[5], 32'd4);
        chk("R8 immediate write to zero register ignored", dmem[6], 32'd0);
        chk("R8 register-form write to zero register ignored", dmem[7], 32'd0);
        chk("R7 store with negative offset", dmem[10], 32'd4);
        chk("R6 load with negative offset", dmem[8], 32'hCAFEF00D);
        chk("R7 store leaves source register unchanged", dmem[13], 32'd4);

        // Reset with a store at the reset vector: no write, PC returns.
        clear_mem();
        imem[0] = enc_i(6'h2B, 5'd0, 5'd0, 16'd4);
        dmem[1] = 32'h00000077;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 no store strobe during reset", {31'b0, dmem_we}, 32'd0);
        chk("R1 PC held at reset vector", imem_addr, 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 memory untouched during reset", dmem[1], 32'h00000077);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule